// File: doc/BRIEF.md
# Byte-Wide Synchronous FIFO Bridge Link

This block sits between the system logic of an FPGA and an external USB 2.0 bridge device. The bridge runs an 8-bit synchronous FIFO interface and supplies its own 60 MHz interface clock. All handshaking with the bridge runs on that clock. The system logic runs on a separate 100 MHz clock and hands over two kinds of outbound packet. Each packet arrives as one parallel word together with a single-cycle request strobe. A data packet is 11 bytes long and a status packet is 26 bytes long.

Each accepted request is held in a system-domain register. A toggle passes it through a three-flop synchronizer into the bridge clock domain. There a byte-index multiplexer walks the held word, least significant byte first. It presents one byte per transfer while the bridge reports free transmit space. The block also reads host commands from the bridge. A separate state machine turns the bus around and collects exactly four bytes into a 32-bit command word. A second toggle handshake returns that word to the system domain, together with a one-cycle valid pulse.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While either reset is high and right after it, rd_n, wr_n and oe_n are high, bus_d_oe is low, cmd_valid is low and tx_overflow is low.
- R2: An accepted data request sends exactly 11 bytes. Byte k equals data_word[8k+7:8k], sent in the order k = 0 to 10. A byte is transferred on each bus_clk rising edge where wr_n is low.
- R3: An accepted status request sends exactly 26 bytes. Byte k equals stat_word[8k+7:8k], sent in the order k = 0 to 25, under the same transfer rule.
- R4: wr_n is low only while txe_n is low. When txe_n goes high in the middle of a packet, the byte index holds, and the packet resumes with that same byte. No byte is skipped or repeated.
- R5: When a data request and a status request become pending together, the whole data packet goes out before the status packet.
- R6: A command read begins with one bus_clk cycle in which oe_n is low, rd_n is high and bus_d_oe is low. After that, rd_n stays low until the fourth byte. A byte is taken on each edge where rd_n and rxf_n are both low. While rxf_n is high the reader waits and takes nothing.
- R7: The first command byte read lands in cmd_word[31:24], the second in [23:16], the third in [15:8] and the fourth in [7:0]. Each command is signalled by cmd_valid high for exactly one sys_clk cycle. cmd_word changes only in a cycle where cmd_valid is high.
- R8: No command read starts while a packet is pending or being sent. A packet does not start while a command read is in progress.
- R9: A request on a channel whose previous packet has not finished is dropped. The packet already accepted is sent unchanged, and tx_overflow goes high and stays high until reset.
- R10: flush_n is held high at all times.
- R11: rd_n and wr_n are never low together. The block drives the data bus (bus_d_oe high) only while a packet is being sent, and never while oe_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock (100 MHz nominal) |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| data_req | input | 1 | One-cycle request to send a data packet |
| data_word | input | 88 | Data packet contents, byte 0 in the low bits |
| stat_req | input | 1 | One-cycle request to send a status packet |
| stat_word | input | 208 | Status packet contents, byte 0 in the low bits |
| cmd_valid | output | 1 | One-cycle pulse: a new host command is in cmd_word |
| cmd_word | output | 32 | Last host command received, first byte in the top bits |
| tx_overflow | output | 1 | Sticky flag: a request was dropped |
| bus_clk | input | 1 | Interface clock from the bridge (60 MHz nominal) |
| bus_rst | input | 1 | Synchronous active-high reset, bridge domain |
| bus_d_in | input | 8 | Data bus as seen at the pad input |
| bus_d_out | output | 8 | Byte driven toward the pad |
| bus_d_oe | output | 1 | Pad output enable for the data bus |
| rxf_n | input | 1 | Low while the bridge holds unread host bytes |
| txe_n | input | 1 | Low while the bridge can accept a byte |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Bridge output enable, active low |
| flush_n | output | 1 | Send-immediate line, kept inactive high |

## Verification
Packets of both lengths are sent under several transmit-space patterns: no stalls, isolated one-cycle stalls, a four-cycle burst and alternating cycles. Between them, these separate a correct index hold from an index that skips or repeats a byte at a stall. Both requests raised in the same cycle show whether the arbitration order is right. A second request on a busy channel shows whether the drop rule holds and whether the first word is protected. Commands are read with all four bytes waiting, and again with a gap after the second byte, which tells apart a reader that waits from one that takes stale bytes. Traffic arriving in both directions at once, in either order, shows that a read and a packet never overlap.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;

    localparam int BYTE_W          = 8;
    localparam int DATA_BYTES_DEF  = 11;
    localparam int STAT_BYTES_DEF  = 26;
    localparam int CMD_BYTES_DEF   = 4;
    localparam int SYNC_STAGES_DEF = 3;

    // Outbound sequencer state: which packet the byte index walks
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_STAT = 2'd2
    } tx_state_e;

    // Inbound command reader state
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_TURN = 2'd1,
        RX_READ = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic              wr_n;
        logic              drive;
        logic [BYTE_W-1:0] dout;
    } tx_bus_t;

    typedef struct packed {
        logic rd_n;
        logic oe_n;
    } rx_bus_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int STAGES = 3
) (
    input  logic dst_clk,
    input  logic dst_rst,
    input  logic src_tgl,
    output logic dst_pulse
);
    // STAGES synchronizing flops plus one for edge detection
    logic [STAGES:0] chain;

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], src_tgl};
        end
    end

    assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/tx_req_port.sv
module tx_req_port #(
    parameter int W = 88
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] word,
    input  logic         done_pulse,
    output logic [W-1:0] hold_word,
    output logic         tgl,
    output logic         drop
);
    logic busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_word <= '0;
            tgl       <= 1'b0;
            busy      <= 1'b0;
            drop      <= 1'b0;
        end else begin
            drop <= 1'b0;
            if (done_pulse) begin
                busy <= 1'b0;
            end
            if (req) begin
                if (busy) begin
                    drop <= 1'b1;
                end else begin
                    hold_word <= word;
                    tgl       <= ~tgl;
                    busy      <= 1'b1;
                end
            end
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(hold_word));

    // R9
    drop_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req && busy) |=> (drop && $stable(tgl)));

endmodule

// File: rtl/tx_engine.sv
module tx_engine
    import usb_bridge_pkg::*;
#(
    parameter int DATA_BYTES = DATA_BYTES_DEF,
    parameter int STAT_BYTES = STAT_BYTES_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         data_pulse,
    input  logic                         stat_pulse,
    input  logic [DATA_BYTES*BYTE_W-1:0] data_word,
    input  logic [STAT_BYTES*BYTE_W-1:0] stat_word,
    input  logic                         txe_n,
    input  logic                         rd_busy,
    output tx_bus_t                      bus,
    output logic                         pend,
    output logic                         active,
    output logic                         data_done_tgl,
    output logic                         stat_done_tgl
);
    localparam int IDX_W  = $clog2(max_int(DATA_BYTES, STAT_BYTES));
    localparam int DSEL_W = $clog2(DATA_BYTES);
    localparam int SSEL_W = $clog2(STAT_BYTES);

    tx_state_e         st;
    logic [IDX_W-1:0]  idx;
    logic              dat_pend;
    logic              sta_pend;
    logic [BYTE_W-1:0] cur_byte;
    logic              xfer;
    logic              last_byte;

    logic [BYTE_W-1:0] dbytes [DATA_BYTES];
    logic [BYTE_W-1:0] sbytes [STAT_BYTES];

    // Split each parallel word into its byte lanes for the index mux
    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_dbyte
        assign dbytes[g] = data_word[g*BYTE_W +: BYTE_W];
    end
    for (genvar g = 0; g < STAT_BYTES; g++) begin : g_sbyte
        assign sbytes[g] = stat_word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        case (st)
            TX_DATA: cur_byte = dbytes[idx[DSEL_W-1:0]];
            TX_STAT: cur_byte = sbytes[idx[SSEL_W-1:0]];
            default: cur_byte = '0;
        endcase
    end

    assign xfer      = (st != TX_IDLE) && !txe_n;
    assign last_byte = (st == TX_DATA) ? (idx == IDX_W'(DATA_BYTES - 1))
                                       : (idx == IDX_W'(STAT_BYTES - 1));
    assign pend      = dat_pend | sta_pend;
    assign active    = (st != TX_IDLE);

    always_comb begin
        bus.wr_n  = !xfer;
        bus.drive = active;
        bus.dout  = cur_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= TX_IDLE;
            idx           <= '0;
            dat_pend      <= 1'b0;
            sta_pend      <= 1'b0;
            data_done_tgl <= 1'b0;
            stat_done_tgl <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: begin
                    idx <= '0;
                    if (!rd_busy) begin
                        if (dat_pend) begin
                            st       <= TX_DATA;
                            dat_pend <= 1'b0;
                        end else if (sta_pend) begin
                            st       <= TX_STAT;
                            sta_pend <= 1'b0;
                        end
                    end
                end
                TX_DATA, TX_STAT: begin
                    if (xfer) begin
                        if (last_byte) begin
                            st <= TX_IDLE;
                            if (st == TX_DATA) begin
                                data_done_tgl <= ~data_done_tgl;
                            end else begin
                                stat_done_tgl <= ~stat_done_tgl;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
            // a fresh request is recorded after any clear above
            if (data_pulse) dat_pend <= 1'b1;
            if (stat_pulse) sta_pend <= 1'b1;
        end
    end

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && txe_n) |=> (idx == $past(idx) && st == $past(st)));

    // R2
    pkt_start_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE) |=> (st == TX_IDLE || idx == '0));

    // R8
    no_start_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE && rd_busy) |=> (st == TX_IDLE));

endmodule

// File: rtl/cmd_reader.sv
module cmd_reader
    import usb_bridge_pkg::*;
#(
    parameter int CMD_BYTES = CMD_BYTES_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rxf_n,
    input  logic [BYTE_W-1:0]           din,
    input  logic                        tx_block,
    output rx_bus_t                     bus,
    output logic                        busy,
    output logic [CMD_BYTES*BYTE_W-1:0] cmd_hold,
    output logic                        cmd_tgl
);
    localparam int CMD_W = CMD_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(CMD_BYTES);

    rx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  work;
    logic [CMD_W-1:0]  next_work;
    logic              take;

    assign take      = (st == RX_READ) && !rxf_n;
    assign next_work = {work[CMD_W-BYTE_W-1:0], din};
    assign busy      = (st != RX_IDLE);

    always_comb begin
        bus.rd_n = (st != RX_READ);
        bus.oe_n = (st == RX_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            cnt      <= '0;
            work     <= '0;
            cmd_hold <= '0;
            cmd_tgl  <= 1'b0;
        end else begin
            case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!rxf_n && !tx_block) begin
                        st <= RX_TURN;
                    end
                end
                RX_TURN: st <= RX_READ;
                RX_READ: begin
                    if (take) begin
                        work <= next_work;
                        if (cnt == CNT_W'(CMD_BYTES - 1)) begin
                            cmd_hold <= next_work;
                            cmd_tgl  <= ~cmd_tgl;
                            st       <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R6
    turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus.rd_n && $past(bus.rd_n)) |-> !$past(bus.oe_n));

    // R6
    rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RX_READ && rxf_n) |=> (st == RX_READ && cnt == $past(cnt)));

endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge
    import usb_bridge_pkg::*;
#(
    parameter int DATA_BYTES  = DATA_BYTES_DEF,
    parameter int STAT_BYTES  = STAT_BYTES_DEF,
    parameter int CMD_BYTES   = CMD_BYTES_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                         sys_clk,
    input  logic                         sys_rst,
    input  logic                         data_req,
    input  logic [DATA_BYTES*BYTE_W-1:0] data_word,
    input  logic                         stat_req,
    input  logic [STAT_BYTES*BYTE_W-1:0] stat_word,
    output logic                         cmd_valid,
    output logic [CMD_BYTES*BYTE_W-1:0]  cmd_word,
    output logic                         tx_overflow,
    input  logic                         bus_clk,
    input  logic                         bus_rst,
    input  logic [BYTE_W-1:0]            bus_d_in,
    output logic [BYTE_W-1:0]            bus_d_out,
    output logic                         bus_d_oe,
    input  logic                         rxf_n,
    input  logic                         txe_n,
    output logic                         rd_n,
    output logic                         wr_n,
    output logic                         oe_n,
    output logic                         flush_n
);
    localparam int DATA_W = DATA_BYTES * BYTE_W;
    localparam int STAT_W = STAT_BYTES * BYTE_W;
    localparam int CMD_W  = CMD_BYTES * BYTE_W;

    logic [DATA_W-1:0] d_hold;
    logic [STAT_W-1:0] s_hold;
    logic              d_tgl, s_tgl, d_drop, s_drop;
    logic              d_pulse, s_pulse;
    logic              d_done_tgl, s_done_tgl, d_done, s_done;
    logic              tx_pend, tx_active, rx_busy;
    logic [CMD_W-1:0]  cmd_hold;
    logic              cmd_tgl, cmd_pulse;
    tx_bus_t           tx_bus;
    rx_bus_t           rx_bus;

    // ---------------- system domain request ports ----------------
    tx_req_port #(.W(DATA_W)) u_dreq (
        .clk(sys_clk), .rst(sys_rst), .req(data_req), .word(data_word),
        .done_pulse(d_done), .hold_word(d_hold), .tgl(d_tgl), .drop(d_drop)
    );

    tx_req_port #(.W(STAT_W)) u_sreq (
        .clk(sys_clk), .rst(sys_rst), .req(stat_req), .word(stat_word),
        .done_pulse(s_done), .hold_word(s_hold), .tgl(s_tgl), .drop(s_drop)
    );

    // ---------------- crossings ----------------
    toggle_sync #(.STAGES(SYNC_STAGES)) u_dsync (
        .dst_clk(bus_clk), .dst_rst(bus_rst), .src_tgl(d_tgl), .dst_pulse(d_pulse)
    );
    toggle_sync #(.STAGES(SYNC_STAGES)) u_ssync (
        .dst_clk(bus_clk), .dst_rst(bus_rst), .src_tgl(s_tgl), .dst_pulse(s_pulse)
    );
    toggle_sync #(.STAGES(SYNC_STAGES)) u_ddone (
        .dst_clk(sys_clk), .dst_rst(sys_rst), .src_tgl(d_done_tgl), .dst_pulse(d_done)
    );
    toggle_sync #(.STAGES(SYNC_STAGES)) u_sdone (
        .dst_clk(sys_clk), .dst_rst(sys_rst), .src_tgl(s_done_tgl), .dst_pulse(s_done)
    );
    toggle_sync #(.STAGES(SYNC_STAGES)) u_csync (
        .dst_clk(sys_clk), .dst_rst(sys_rst), .src_tgl(cmd_tgl), .dst_pulse(cmd_pulse)
    );

    // ---------------- bridge domain engines ----------------
    tx_engine #(.DATA_BYTES(DATA_BYTES), .STAT_BYTES(STAT_BYTES)) u_tx (
        .clk(bus_clk), .rst(bus_rst),
        .data_pulse(d_pulse), .stat_pulse(s_pulse),
        .data_word(d_hold), .stat_word(s_hold),
        .txe_n(txe_n), .rd_busy(rx_busy),
        .bus(tx_bus), .pend(tx_pend), .active(tx_active),
        .data_done_tgl(d_done_tgl), .stat_done_tgl(s_done_tgl)
    );

    cmd_reader #(.CMD_BYTES(CMD_BYTES)) u_rx (
        .clk(bus_clk), .rst(bus_rst), .rxf_n(rxf_n), .din(bus_d_in),
        .tx_block(tx_pend | tx_active),
        .bus(rx_bus), .busy(rx_busy), .cmd_hold(cmd_hold), .cmd_tgl(cmd_tgl)
    );

    assign bus_d_out = tx_bus.dout;
    assign bus_d_oe  = tx_bus.drive;
    assign wr_n      = tx_bus.wr_n;
    assign rd_n      = rx_bus.rd_n;
    assign oe_n      = rx_bus.oe_n;
    assign flush_n   = 1'b1;

    // ---------------- system domain results ----------------
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            tx_overflow <= 1'b0;
            cmd_valid   <= 1'b0;
            cmd_word    <= '0;
        end else begin
            if (d_drop || s_drop) begin
                tx_overflow <= 1'b1;
            end
            cmd_valid <= cmd_pulse;
            if (cmd_pulse) begin
                cmd_word <= cmd_hold;
            end
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !(!rd_n && !wr_n));

    // R11
    drive_dir_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        bus_d_oe |-> oe_n);

    // R9
    ovf_sticky_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        tx_overflow |=> tx_overflow);

    // R7
    cmd_pulse_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        cmd_valid |=> !cmd_valid);

    // R7
    cmd_stable_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !cmd_valid |-> $stable(cmd_word));

endmodule

// File: tb/usb_fifo_bridge_tb.sv
module usb_fifo_bridge_tb;

    localparam int DB = 11;
    localparam int SB = 26;
    localparam int DW = DB * 8;
    localparam int SW = SB * 8;

    // {is_status, seed, stall mask}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'h11, 8'h00},
        {1'b1, 8'h22, 8'h00},
        {1'b0, 8'h33, 8'h24},
        {1'b1, 8'h44, 8'hF0},
        {1'b0, 8'h55, 8'h55},
        {1'b1, 8'h66, 8'h81}
    };

    logic sys_clk = 1'b0;
    logic bus_clk = 1'b0;
    always #10 sys_clk = ~sys_clk;   // 50 MHz
    always #15 bus_clk = ~bus_clk;

    logic          sys_rst, bus_rst;
    logic          data_req, stat_req;
    logic [DW-1:0] data_word;
    logic [SW-1:0] stat_word;
    logic          cmd_valid, tx_overflow;
    logic [31:0]   cmd_word;
    logic [7:0]    bus_d_in, bus_d_out;
    logic          bus_d_oe, rxf_n, txe_n, rd_n, wr_n, oe_n, flush_n;

    usb_fifo_bridge u_dut (
        .sys_clk(sys_clk), .sys_rst(sys_rst),
        .data_req(data_req), .data_word(data_word),
        .stat_req(stat_req), .stat_word(stat_word),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .tx_overflow(tx_overflow),
        .bus_clk(bus_clk), .bus_rst(bus_rst),
        .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .rxf_n(rxf_n), .txe_n(txe_n), .rd_n(rd_n), .wr_n(wr_n),
        .oe_n(oe_n), .flush_n(flush_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bridge model state
    logic [7:0] q_mem [16];
    int   q_wr = 0, q_rd = 0;
    bit   pop_pend = 0;
    bit   tx_hold = 1;
    logic [7:0] stall_mask = 8'h00;
    int   bcyc = 0;
    logic [7:0] cap [64];
    int   cap_n = 0;

    int strobe_err = 0, bad_drive = 0, flush_err = 0, stall_err = 0;
    int turn_seen = 0, turn_err = 0;
    logic prev_rd_n = 1'b1, prev_oe_n = 1'b1, prev_doe = 1'b0;
    int cmd_cnt = 0, cmd_stab_err = 0;
    logic [31:0] cmd_last = '0, cmd_prev = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(input logic [7:0] seed, input int k);
        return (seed + 8'(k * 29)) ^ 8'(k);
    endfunction

    function automatic logic [SW-1:0] gen_word(input logic [7:0] seed);
        logic [SW-1:0] w;
        for (int k = 0; k < SB; k++) w[k*8 +: 8] = gen_byte(seed, k);
        return w;
    endfunction

    // bridge driver: inputs change shortly after the rising edge
    initial begin
        rxf_n = 1'b1; txe_n = 1'b1; bus_d_in = '0;
        forever begin
            @(posedge bus_clk);
            #2;
            if (pop_pend) begin
                q_rd++;
                pop_pend = 0;
            end
            txe_n    = tx_hold | stall_mask[bcyc % 8];
            bcyc++;
            rxf_n    = (q_rd == q_wr);
            bus_d_in = q_mem[q_rd % 16];
        end
    end

    // bridge monitor: sample mid-cycle, the next rising edge uses these values
    initial begin
        forever begin
            @(negedge bus_clk);
            if (!bus_rst) begin
                pop_pend = (!rd_n && !rxf_n);
                if (!wr_n) begin
                    if (!bus_d_oe) bad_drive++;
                    if (cap_n < 64) cap[cap_n] = bus_d_out;
                    cap_n++;
                end
                if (!wr_n && !rd_n) strobe_err++;
                if (bus_d_oe && !oe_n) bad_drive++;
                if (!flush_n) flush_err++;
                if (txe_n && !wr_n) stall_err++;
                if (!rd_n && prev_rd_n) begin
                    turn_seen++;
                    if (!(prev_oe_n == 1'b0 && prev_doe == 1'b0)) turn_err++;
                end
                prev_rd_n = rd_n;
                prev_oe_n = oe_n;
                prev_doe  = bus_d_oe;
            end
        end
    end

    // system-side command monitor
    initial begin
        forever begin
            @(negedge sys_clk);
            if (!sys_rst) begin
                if (cmd_valid) begin
                    cmd_cnt++;
                    cmd_last = cmd_word;
                end else if (cmd_word != cmd_prev) begin
                    cmd_stab_err++;
                end
                cmd_prev = cmd_word;
            end
        end
    end

    task automatic bus_wait(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic sys_wait(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic send(input bit do_d, input bit do_s,
                        input logic [7:0] dseed, input logic [7:0] sseed);
        @(negedge sys_clk);
        data_word = gen_word(dseed)[DW-1:0];
        stat_word = gen_word(sseed);
        data_req  = do_d;
        stat_req  = do_s;
        @(negedge sys_clk);
        data_req  = 1'b0;
        stat_req  = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        q_mem[q_wr % 16] = b;
        q_wr++;
    endtask

    task automatic wait_cap(input int n);
        for (int i = 0; i < 3000 && cap_n < n; i++) @(negedge bus_clk);
    endtask

    task automatic wait_cmd(input int c0);
        for (int i = 0; i < 600 && cmd_cnt == c0; i++) @(negedge sys_clk);
    endtask

    task automatic cmp_bytes(input int off, input logic [7:0] seed, input int n,
                             input string req);
        int bad = -1;
        for (int k = 0; k < n; k++) begin
            if (bad < 0 && cap[off + k] !== gen_byte(seed, k)) bad = k;
        end
        check(bad < 0, req, $sformatf("byte stream (first bad index %0d)", bad),
              (bad < 0) ? 32'h0 : 32'(cap[off + bad]),
              (bad < 0) ? 32'h0 : 32'(gen_byte(seed, bad)));
    endtask

    initial begin
        #(100_000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        int qr0;
        sys_rst = 1'b1; bus_rst = 1'b1;
        data_req = 1'b0; stat_req = 1'b0;
        data_word = '0; stat_word = '0;
        sys_wait(6);
        @(negedge sys_clk) sys_rst = 1'b0;
        @(negedge bus_clk) bus_rst = 1'b0;
        bus_wait(3);

        // R1: idle state after reset
        check(rd_n && wr_n && oe_n, "R1", "strobes idle", {rd_n, wr_n, oe_n}, 3'b111);
        check(!bus_d_oe, "R1", "bus not driven", bus_d_oe, 0);
        @(negedge sys_clk);
        check(!cmd_valid && !tx_overflow, "R1", "valid/overflow low",
              {cmd_valid, tx_overflow}, 0);

        // table of packets under different stall patterns (R2, R3, R4)
        tx_hold = 0;
        for (int i = 0; i < 6; i++) begin
            logic [16:0] v;
            int n;
            v = VEC[i];
            n = v[16] ? SB : DB;
            stall_mask = v[7:0];
            cap_n = 0;
            send(!v[16], v[16], v[15:8], v[15:8]);
            wait_cap(n);
            bus_wait(20);
            check(cap_n == n, v[16] ? "R3" : "R2", "byte count R4", cap_n, n);
            cmp_bytes(0, v[15:8], n, v[16] ? "R3 R4" : "R2 R4");
        end
        stall_mask = 8'h00;

        // R5: both pending together, data goes first
        tx_hold = 1;
        cap_n = 0;
        send(1, 1, 8'h3C, 8'hC3);
        bus_wait(20);
        check(cap_n == 0, "R4", "no write while txe_n high", cap_n, 0);
        tx_hold = 0;
        wait_cap(DB + SB);
        bus_wait(20);
        check(cap_n == DB + SB, "R5", "total bytes", cap_n, DB + SB);
        cmp_bytes(0, 8'h3C, DB, "R5 data first");
        cmp_bytes(DB, 8'hC3, SB, "R5 status second");

        // R9: second request while first still outstanding
        tx_hold = 1;
        cap_n = 0;
        send(1, 0, 8'h5A, 8'h00);
        sys_wait(15);
        send(1, 0, 8'hA5, 8'h00);
        sys_wait(3);
        check(tx_overflow == 1'b1, "R9", "overflow set", tx_overflow, 1);
        tx_hold = 0;
        wait_cap(DB);
        bus_wait(40);
        check(cap_n == DB, "R9", "only first packet sent", cap_n, DB);
        cmp_bytes(0, 8'h5A, DB, "R9");
        sys_wait(5);
        check(tx_overflow == 1'b1, "R9", "overflow sticky", tx_overflow, 1);

        // R7, R6: command with all bytes waiting
        c0 = cmd_cnt;
        push(8'hA1); push(8'hB2); push(8'hC3); push(8'hD4);
        wait_cmd(c0);
        sys_wait(20);
        check(cmd_cnt == c0 + 1, "R7", "one valid pulse", cmd_cnt - c0, 1);
        check(cmd_last == 32'hA1B2C3D4, "R7", "command order", cmd_last, 32'hA1B2C3D4);
        check(turn_seen > 0 && turn_err == 0, "R6", "turnaround cycle", turn_err, 0);

        // R6: gap after second byte
        c0 = cmd_cnt;
        push(8'h11); push(8'h22);
        bus_wait(30);
        check(cmd_cnt == c0, "R6", "reader waits on rxf_n", cmd_cnt - c0, 0);
        push(8'h33); push(8'h44);
        wait_cmd(c0);
        sys_wait(5);
        check(cmd_last == 32'h11223344, "R6", "gapped command", cmd_last, 32'h11223344);

        // R8: no read while a packet is in progress
        tx_hold = 1;
        cap_n = 0;
        send(0, 1, 8'h00, 8'h77);
        sys_wait(15);
        qr0 = q_rd;
        c0 = cmd_cnt;
        push(8'hDE); push(8'hAD); push(8'hBE); push(8'hEF);
        bus_wait(30);
        check(q_rd == qr0, "R8", "no bytes read during packet", q_rd - qr0, 0);
        tx_hold = 0;
        wait_cap(SB);
        wait_cmd(c0);
        bus_wait(10);
        cmp_bytes(0, 8'h77, SB, "R8");
        check(cmd_last == 32'hDEADBEEF, "R8", "command after packet", cmd_last, 32'hDEADBEEF);

        // R8: packet waits for a read in progress
        cap_n = 0;
        c0 = cmd_cnt;
        push(8'h01); push(8'h02);
        bus_wait(10);
        send(1, 0, 8'h99, 8'h00);
        bus_wait(30);
        check(cap_n == 0, "R8", "packet held during read", cap_n, 0);
        push(8'h03); push(8'h04);
        wait_cap(DB);
        wait_cmd(c0);
        bus_wait(10);
        check(cmd_last == 32'h01020304, "R8", "read completed first", cmd_last, 32'h01020304);
        cmp_bytes(0, 8'h99, DB, "R8");

        // whole-run observations
        check(strobe_err == 0, "R11", "rd_n and wr_n both low", strobe_err, 0);
        check(bad_drive == 0, "R11", "bus drive outside packet", bad_drive, 0);
        check(flush_err == 0, "R10", "flush_n low seen", flush_err, 0);
        check(stall_err == 0, "R4", "write during stall", stall_err, 0);
        check(cmd_stab_err == 0, "R7", "cmd_word changed without valid", cmd_stab_err, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule